// File: doc/BRIEF.md
# DMA Request and Interrupt Router

This block sits between a bank of peripheral event sources, the per-channel request inputs of a DMA engine and the inputs of a CPU interrupt controller. It has one routing lane per channel. A software-visible enable bit for each channel decides whether that channel's peripheral event is treated as an interrupt or as a DMA transfer request. The engine's per-channel transfer-complete interrupt is passed on to the controller whenever the channel's wiring allows it.

Each channel's wiring is fixed at build time by a two-bit kind field in a parameter vector. A shared-line channel has one controller input. That input carries the peripheral interrupt while the enable bit is clear, and carries the engine's completion interrupt while the bit is set; in the second case the peripheral event becomes the DMA request. A split-line channel has a separate transfer-request wire and a dedicated controller input for completion. There, the enable bit gates only the DMA request. A channel that is not DMA-capable never requests a transfer.

The enable bits are reached through a small synchronous word-wide register port. Every output is registered.

Top module: `dreq_irq_router`

## Requirements
- R1: While reset is asserted, all enable bits are cleared and every output (DMA request, both controller input vectors, read data) is 0.
- R2: On a shared-line channel (kind code 1) with enable clear, the controller input follows the peripheral interrupt, the DMA request is 0, and the completion interrupt has no effect.
- R3: On a shared-line channel with enable set, the DMA request follows the peripheral interrupt, and the controller input follows the engine's completion interrupt instead of the peripheral interrupt.
- R4: On a split-line channel (kind code 2), the controller input follows the peripheral interrupt for both enable values.
- R5: On a split-line channel, the DMA request equals enable AND transfer-request. The transfer-request wire never affects a controller input. It is ignored on shared and non-capable channels.
- R6: On a split-line channel, the dedicated completion output follows the engine's completion interrupt for both enable values. On every other channel this output is 0.
- R7: On a non-capable channel (kind code 0), the DMA request is always 0 and the controller input follows the peripheral interrupt. Its enable bit cannot be set and reads back as 0.
- R8: Register word k holds channels 32k to 32k+31, with bit j holding channel 32k+j. A write updates the word at the clock edge. Read data is registered and shows the word addressed at the edge as it stood before any write at that same edge.
- R9: Outputs at each clock edge reflect the inputs and enable bits present just before that edge. A change to an enable bit first affects the outputs at the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| per_irq | input | NUM_CH | Peripheral interrupt/event, one per channel |
| per_xreq | input | NUM_CH | Separate transfer request (split-line channels only) |
| eng_done | input | NUM_CH | Engine transfer-complete interrupt per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dma_req | output | NUM_CH | Transfer request to the DMA engine |
| ic_irq | output | NUM_CH | Per-channel interrupt controller input |
| ic_done | output | NUM_CH | Dedicated completion controller input (split-line channels) |

## Verification
The hardest situation to reach from the ports is a shared-line channel whose enable bit flips while its peripheral interrupt and the completion interrupt are both toggling. In that case the controller input must change source on exactly the edge after the write, and a glitch or a one-cycle slip would be hidden if the two sources happened to agree. The stimulus drives independent random patterns on all three input vectors every cycle and issues random word writes in the middle of that traffic. A directed step holds one shared channel's interrupt high across an enabling write and checks the hand-over cycle by cycle.

// File: rtl/rtr_pkg.sv
`timescale 1ns/1ps
package rtr_pkg;
   localparam int MAX_CH = 256;
   localparam int WORD_W = 32;

   typedef enum logic [1:0] {
      CH_NONE   = 2'd0,
      CH_SHARED = 2'd1,
      CH_SPLIT  = 2'd2
   } ch_kind_e;

   // one bit per channel that is allowed to request a transfer
   function automatic logic [MAX_CH-1:0] cap_mask(input logic [2*MAX_CH-1:0] kinds);
      logic [MAX_CH-1:0] m;
      m = '0;
      for (int i = 0; i < MAX_CH; i++) begin
         m[i] = (kinds[2*i +: 2] != 2'd0);
      end
      return m;
   endfunction
endpackage

// File: rtl/rtr_enable_regs.sv
`timescale 1ns/1ps
module rtr_enable_regs #(
   parameter int NUM_CH = 256,
   parameter logic [2*rtr_pkg::MAX_CH-1:0] CH_KIND = '0,
   parameter int AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic [NUM_CH-1:0] en_o
);
   localparam int WORDS = NUM_CH / rtr_pkg::WORD_W;
   localparam logic [rtr_pkg::MAX_CH-1:0] CAP = rtr_pkg::cap_mask(CH_KIND);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [31:0] WMASK = CAP[32*w +: 32];
      logic [31:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= '0;
         end else if (we && addr == AW'(w)) begin
            q <= wdata & WMASK;
         end
      end
      assign en_o[32*w +: 32] = q;

      // R8
      wr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == AW'(w)) |=> (en_o[32*w +: 32] == ($past(wdata) & WMASK)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (int'(addr) < WORDS) begin
         rdata <= en_o[32*int'(addr) +: 32];
      end else begin
         rdata <= '0;
      end
   end
endmodule

// File: rtl/rtr_lane.sv
`timescale 1ns/1ps
module rtr_lane #(
   parameter logic [1:0] KIND = 2'd0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic irq_i,
   input  logic xreq_i,
   input  logic done_i,
   output logic dma_req_o,
   output logic ic_irq_o,
   output logic ic_done_o
);
   logic req_d, irq_d, done_d;

   if (KIND == rtr_pkg::CH_SHARED) begin : g_shared
      logic unused_in;
      assign unused_in = xreq_i;
      always_comb begin
         req_d  = en_i & irq_i;
         irq_d  = en_i ? done_i : irq_i;
         done_d = 1'b0;
      end

      // R3
      shr_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dma_req_o |-> ($past(en_i) && $past(irq_i)));
      // R2
      shr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && !$past(en_i)) |-> (ic_irq_o == $past(irq_i)));
   end else if (KIND == rtr_pkg::CH_SPLIT) begin : g_split
      always_comb begin
         req_d  = en_i & xreq_i;
         irq_d  = irq_i;
         done_d = done_i;
      end

      // R4
      spl_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (ic_irq_o == $past(irq_i)));
      // R5
      spl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dma_req_o |-> $past(en_i && xreq_i));
      // R6
      spl_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (ic_done_o == $past(done_i)));
   end else if (KIND == rtr_pkg::CH_NONE) begin : g_none
      logic unused_in;
      assign unused_in = ^{en_i, xreq_i, done_i};
      always_comb begin
         req_d  = 1'b0;
         irq_d  = irq_i;
         done_d = 1'b0;
      end

      // R7
      non_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $past(rst_n) |-> (ic_irq_o == $past(irq_i)));
   end else begin : g_bad_kind
      $error("rtr_lane: channel kind code 3 is not defined");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dma_req_o <= 1'b0;
         ic_irq_o  <= 1'b0;
         ic_done_o <= 1'b0;
      end else begin
         dma_req_o <= req_d;
         ic_irq_o  <= irq_d;
         ic_done_o <= done_d;
      end
   end
endmodule

// File: rtl/dreq_irq_router.sv
`timescale 1ns/1ps
module dreq_irq_router #(
   parameter int NUM_CH = 256,
   parameter logic [2*rtr_pkg::MAX_CH-1:0] CH_KIND = {32{16'b10_00_01_10_01_00_10_01}},
   localparam int WORDS = NUM_CH / rtr_pkg::WORD_W,
   localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] per_irq,
   input  logic [NUM_CH-1:0] per_xreq,
   input  logic [NUM_CH-1:0] eng_done,
   input  logic              reg_we,
   input  logic [AW-1:0]     reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic [NUM_CH-1:0] dma_req,
   output logic [NUM_CH-1:0] ic_irq,
   output logic [NUM_CH-1:0] ic_done
);
   if (NUM_CH % rtr_pkg::WORD_W != 0 || NUM_CH < rtr_pkg::WORD_W ||
       NUM_CH > rtr_pkg::MAX_CH) begin : g_bad_num_ch
      $error("dreq_irq_router: NUM_CH must be a multiple of 32 between 32 and 256");
   end

   logic [NUM_CH-1:0] en;

   rtr_enable_regs #(
      .NUM_CH (NUM_CH),
      .CH_KIND(CH_KIND),
      .AW     (AW)
   ) u_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (reg_we),
      .addr (reg_addr),
      .wdata(reg_wdata),
      .rdata(reg_rdata),
      .en_o (en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      rtr_lane #(.KIND(CH_KIND[2*i +: 2])) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_i     (en[i]),
         .irq_i    (per_irq[i]),
         .xreq_i   (per_xreq[i]),
         .done_i   (eng_done[i]),
         .dma_req_o(dma_req[i]),
         .ic_irq_o (ic_irq[i]),
         .ic_done_o(ic_done[i])
      );
   end
endmodule

// File: tb/sim_dreq_irq_router.sv
`timescale 1ns/1ps
module sim_dreq_irq_router;
   localparam int N = 256;
   localparam int W = 8;

   function automatic logic [1:0] kind_of(input int i);
      case (i % 8)
         0, 3, 5: return 2'd1;
         1, 4, 7: return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

   function automatic logic [2*N-1:0] build_kinds();
      logic [2*N-1:0] r;
      for (int i = 0; i < N; i++) r[2*i +: 2] = kind_of(i);
      return r;
   endfunction

   localparam logic [2*N-1:0] TB_KINDS = build_kinds();

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic [N-1:0] per_irq = '0, per_xreq = '0, eng_done = '0;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] dma_req, ic_irq, ic_done;

   always #2.5 clk = ~clk;

   dreq_irq_router #(.NUM_CH(N), .CH_KIND(TB_KINDS)) u0 (
      .clk(clk), .rst_n(rst_n), .per_irq(per_irq), .per_xreq(per_xreq),
      .eng_done(eng_done), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
      .ic_irq(ic_irq), .ic_done(ic_done)
   );

   int n_checks = 0;
   int n_fail = 0;
   bit armed = 0;
   bit done_flag = 0;

   logic [N-1:0] model_en = '0;
   logic [N-1:0] exp_req = '0, exp_ic = '0, exp_done = '0;
   logic [31:0] exp_rd = '0;

   // behavioural reference: what each edge must produce
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_en = '0; exp_req = '0; exp_ic = '0; exp_done = '0; exp_rd = '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            case (kind_of(i))
               2'd1: begin
                  exp_req[i]  = model_en[i] & per_irq[i];
                  exp_ic[i]   = model_en[i] ? eng_done[i] : per_irq[i];
                  exp_done[i] = 1'b0;
               end
               2'd2: begin
                  exp_req[i]  = model_en[i] & per_xreq[i];
                  exp_ic[i]   = per_irq[i];
                  exp_done[i] = eng_done[i];
               end
               default: begin
                  exp_req[i]  = 1'b0;
                  exp_ic[i]   = per_irq[i];
                  exp_done[i] = 1'b0;
               end
            endcase
         end
         exp_rd = model_en[int'(reg_addr)*32 +: 32];
         if (reg_we) begin
            for (int j = 0; j < 32; j++) begin
               model_en[int'(reg_addr)*32 + j] =
                  reg_wdata[j] && (kind_of(int'(reg_addr)*32 + j) != 2'd0);
            end
         end
      end
   end

   function automatic string tag_of(input int path, input int ch, input bit en);
      if (!rst_n) return "R1";
      case (kind_of(ch))
         2'd1: return (path == 2) ? "R6" : (en ? "R3" : "R2");
         2'd2: return (path == 0) ? "R5" : ((path == 1) ? "R4" : "R6");
         default: return (path == 2) ? "R6" : "R7";
      endcase
   endfunction

   task automatic check_vec(input string nm, input int path,
                            input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         for (int i = 0; i < N; i++) begin
            if (act[i] !== exp[i]) begin
               $display("FAIL %s %s ch%0d: actual %b expected %b (vector %h vs %h)",
                        tag_of(path, i, model_en[i]), nm, i, act[i], exp[i], act, exp);
               break;
            end
         end
      end
   endtask

   always @(negedge clk) begin
      if (armed) begin
         check_vec("dma_req", 0, dma_req, exp_req);
         check_vec("ic_irq", 1, ic_irq, exp_ic);
         check_vec("ic_done", 2, ic_done, exp_done);
         n_checks++;
         if (reg_rdata !== exp_rd) begin
            n_fail++;
            $display("FAIL %s reg_rdata: actual %h expected %h",
                     rst_n ? "R8" : "R1", reg_rdata, exp_rd);
         end
      end
   end

   task automatic check_bit(input string tag, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s directed: actual %b expected %b", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] rand_vec(input int density);
      logic [N-1:0] v;
      for (int k = 0; k < W; k++) begin
         v[32*k +: 32] = (density == 0) ? ($urandom & $urandom) : $urandom;
      end
      return v;
   endfunction

   task automatic rand_cycles(input int n, input int wdiv);
      for (int c = 0; c < n; c++) begin
         @(negedge clk); #1;
         per_irq   = rand_vec(c % 2);
         per_xreq  = rand_vec((c / 3) % 2);
         eng_done  = rand_vec((c / 5) % 2);
         reg_addr  = 3'($urandom % W);
         reg_we    = (wdiv > 0) && (($urandom % wdiv) == 0);
         case ($urandom % 4)
            0: reg_wdata = 32'hFFFF_FFFF;
            1: reg_wdata = 32'h5555_5555;
            2: reg_wdata = 32'hAAAA_AAAA;
            default: reg_wdata = $urandom;
         endcase
      end
      @(negedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic write_word(input int a, input logic [31:0] d);
      @(negedge clk); #1;
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      #1 rst_n = 1'b0;
      #1 armed = 1;
      // R1: reset with busy inputs
      per_irq = '1; per_xreq = '1; eng_done = '1;
      repeat (4) @(negedge clk);
      #1 rst_n = 1'b1;
      per_irq = '0; per_xreq = '0; eng_done = '0;

      // all enables clear: every event goes to the controller
      rand_cycles(200, 0);

      // R9: enabling a shared channel with its event held high
      @(negedge clk); #1;
      per_irq = '0; eng_done = '0; per_xreq = '0;
      per_irq[0] = 1'b1;
      reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h0000_0001;
      @(negedge clk);
      check_bit("R9 dma_req before enable takes effect", dma_req[0], 1'b0);
      check_bit("R9 ic_irq before enable takes effect", ic_irq[0], 1'b1);
      #1 reg_we = 1'b0;
      @(negedge clk);
      check_bit("R9 dma_req after enable", dma_req[0], 1'b1);
      check_bit("R9 ic_irq now carries completion", ic_irq[0], 1'b0);

      // set every enable, read every word back
      for (int a = 0; a < W; a++) write_word(a, 32'hFFFF_FFFF);
      rand_cycles(300, 0);

      // enables flipping in the middle of traffic
      rand_cycles(1500, 6);

      // clear everything again, then walk reads
      for (int a = 0; a < W; a++) write_word(a, 32'h0);
      rand_cycles(200, 0);

      // reset in the middle of activity
      for (int a = 0; a < W; a++) write_word(a, 32'hFFFF_FFFF);
      @(negedge clk); #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      rand_cycles(100, 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule